// File: doc/BRIEF.md
# Truncated Inexact Array Multiplier

This block is a purely combinational unsigned multiplier for two N-bit operands (N = 8 by default) that yields a 2N-bit product. AND gates form the partial products. A carry-save array of adder rows reduces them, and a final ripple row resolves the remaining sums and carries. A compile-time cut column discards every gate and adder whose weight column is at or below the cut. This trades accuracy in the low part of the product for area, delay and energy, which suits error-tolerant pixel arithmetic such as blending two 8-bit images.

Two compile-time constants give four variants. The first constant is the value fed into any adder input whose carry source was removed by the cut. Tying it to 0 turns that adder into a half adder. Tying it to 1 turns it into an XNOR for the sum and an OR for the carry. The second constant is the value driven on every product bit at or below the cut. Variants are named by the two digits in that order, so "01" ties open carries to 0 and fills the low bits with 1; "01" with cut 8 is the default. Setting the cut to -1 disables truncation. The product is then exact whatever the two constants are. A cut outside -1..2N-3, or a mode constant other than 0 or 1, stops elaboration with an error.

Top module: `trunc_array_mult`

## Requirements
- R1: With CUT = -1, `prod` equals the exact product a_in * b_in for every operand pair, whatever the two mode constants are.
- R2: For CUT >= 0, every bit prod[k] with k <= CUT equals LOW_FILL for every operand pair.
- R3: With OPEN_TIE = 0, the bits of `prod` above CUT equal the same bits of the sum of all partial products a_in[i]&b_in[j] whose weight i+j exceeds CUT. That value never exceeds the exact product.
- R4: With OPEN_TIE = 1 (N = 8), the bits of `prod` above CUT equal those of (S + n*2^(CUT+1)) mod 2^16. S is the surviving partial-product sum from R3. n is built from three terms: the count of j in 2..7 with j-1 <= CUT <= j+6, plus 1 when 7 <= CUT <= 13, plus 1 when 8 <= CUT <= 13. For example, n = 8 at CUT = 8, n = 2 at CUT = 2 and n = 3 at CUT = 13.
- R5: Two builds that differ only in LOW_FILL produce identical bits above CUT for every operand pair.
- R6: With CUT = 0, only the partial product of the two operand LSBs is removed. prod[15:1] equals bits 15:1 of the exact product for either OPEN_TIE value, and n = 0.
- R7: With CUT = 8 and a zero operand, variant 01 yields 16'h01FF, variant 10 yields 16'h1000 and variant 11 yields 16'h11FF.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| a_in | input | N | Unsigned multiplicand |
| b_in | input | N | Unsigned multiplier |
| prod | output | 2N | Truncated product with low-bit fill |

## Verification
The block holds no state, so every result is due in the same cycle its operands are applied, with zero registers on the path. The bench changes operands just after a rising clock edge and reads every output on the next falling edge, half a period later. Every output has settled by then and no edge is shared. The bench runs one exhaustive 65536-pair sweep against eight builds side by side: four variants at cut 8, plus the exact, cut-0, cut-2 and cut-13 builds. Each output is compared with an arithmetic model of truncation and carry injection.

// File: rtl/trunc_array_mult.sv
module trunc_array_mult #(
  parameter int N        = 8,
  parameter int CUT      = 8,
  parameter int OPEN_TIE = 0,
  parameter int LOW_FILL = 1
) (
  input  logic [N-1:0]   a_in,
  input  logic [N-1:0]   b_in,
  output logic [2*N-1:0] prod
);
  localparam int PW = 2 * N;
  localparam logic TIE  = (OPEN_TIE != 0);
  localparam logic FILL = (LOW_FILL != 0);
  localparam logic [PW-1:0] LOWMASK = PW'((64'd1 << (CUT + 1)) - 64'd1);

  if (N < 2) begin : g_bad_width
    $error("trunc_array_mult: N must be at least 2");
  end
  if (CUT < -1 || CUT > PW - 3) begin : g_bad_cut
    $error("trunc_array_mult: CUT out of range -1..2N-3");
  end
  if (OPEN_TIE != 0 && OPEN_TIE != 1) begin : g_bad_tie
    $error("trunc_array_mult: OPEN_TIE must be 0 or 1");
  end
  if (LOW_FILL != 0 && LOW_FILL != 1) begin : g_bad_fill
    $error("trunc_array_mult: LOW_FILL must be 0 or 1");
  end

  function automatic logic live(input int col);
    return col > CUT;
  endfunction

  logic [N-1:0] s_row [N];
  logic [N-1:0] c_row [N];
  logic [N-1:0] rc;
  logic [PW-1:0] ref_full;

  always_comb begin
    logic x, y, z;
    int col;
    for (int r = 0; r < N; r++) begin
      s_row[r] = '0;
      c_row[r] = '0;
    end
    rc   = '0;
    prod = '0;

    for (int i = 0; i < N; i++)
      s_row[0][i] = live(i) ? (a_in[i] & b_in[0]) : 1'b0;

    for (int j = 1; j < N; j++) begin
      for (int i = 0; i < N; i++) begin
        col = i + j;
        if (live(col)) begin
          x = a_in[i] & b_in[j];
          y = (i < N - 1) ? s_row[j-1][i+1] : 1'b0;
          if (j == 1)             z = 1'b0;
          else if (live(col - 1)) z = c_row[j-1][i];
          else                    z = TIE;
          s_row[j][i] = x ^ y ^ z;
          c_row[j][i] = (x & y) | (z & (x ^ y));
        end
      end
    end

    for (int j = 0; j < N; j++)
      prod[j] = s_row[j][0];

    for (int i = 0; i < N - 1; i++) begin
      col = N + i;
      if (live(col)) begin
        x = s_row[N-1][i+1];
        y = live(col - 1) ? c_row[N-1][i] : TIE;
        if (i == 0)             z = 1'b0;
        else if (live(col - 1)) z = rc[i-1];
        else                    z = TIE;
        prod[col] = x ^ y ^ z;
        rc[i]     = (x & y) | (z & (x ^ y));
      end
    end

    prod[PW-1] = c_row[N-1][N-1] ^ rc[N-2];

    for (int k = 0; k < PW; k++)
      if (!live(k)) prod[k] = FILL;

    ref_full = PW'(a_in) * PW'(b_in);

    if (!$isunknown({a_in, b_in})) begin
      // R1
      if (CUT < 0) begin
        exact_chk: assert (prod == ref_full)
          else $error("exact build differs from a*b");
      end
      // R2
      low_fill_chk: assert ($countones(prod & LOWMASK) == (FILL ? CUT + 1 : 0))
        else $error("low product bits not at fill value");
      // R3
      if (!TIE) begin
        no_gain_chk: assert ((prod & ~LOWMASK) <= ref_full)
          else $error("truncated product above exact product");
      end
      // R6
      if (CUT == 0) begin
        cut0_chk: assert (prod[PW-1:1] == ref_full[PW-1:1])
          else $error("cut 0 disturbed upper product bits");
      end
      // R7
      if (!TIE && (a_in == '0 || b_in == '0)) begin
        zero_operand_chk: assert (prod == (FILL ? LOWMASK : '0))
          else $error("zero operand gave nonzero upper bits");
      end
    end
  end
endmodule

// File: tb/trunc_array_mult_tb.sv
module trunc_array_mult_tb;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG_CYCLES = 200000;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [7:0] a = '0;
  logic [7:0] b = '0;
  int checks = 0;
  int fails = 0;
  bit done = 0;

  logic [15:0] y01, y00, y10, y11, yex, yc0, yc2, yc13;

  always #(CLK_PERIOD / 2) clk = ~clk;

  trunc_array_mult #(.N(8), .CUT(8),  .OPEN_TIE(0), .LOW_FILL(1)) u_dut     (.a_in(a), .b_in(b), .prod(y01));
  trunc_array_mult #(.N(8), .CUT(8),  .OPEN_TIE(0), .LOW_FILL(0)) u_dut_v00 (.a_in(a), .b_in(b), .prod(y00));
  trunc_array_mult #(.N(8), .CUT(8),  .OPEN_TIE(1), .LOW_FILL(0)) u_dut_v10 (.a_in(a), .b_in(b), .prod(y10));
  trunc_array_mult #(.N(8), .CUT(8),  .OPEN_TIE(1), .LOW_FILL(1)) u_dut_v11 (.a_in(a), .b_in(b), .prod(y11));
  trunc_array_mult #(.N(8), .CUT(-1), .OPEN_TIE(1), .LOW_FILL(1)) u_dut_ex  (.a_in(a), .b_in(b), .prod(yex));
  trunc_array_mult #(.N(8), .CUT(0),  .OPEN_TIE(1), .LOW_FILL(0)) u_dut_c0  (.a_in(a), .b_in(b), .prod(yc0));
  trunc_array_mult #(.N(8), .CUT(2),  .OPEN_TIE(1), .LOW_FILL(1)) u_dut_c2  (.a_in(a), .b_in(b), .prod(yc2));
  trunc_array_mult #(.N(8), .CUT(13), .OPEN_TIE(1), .LOW_FILL(0)) u_dut_c13 (.a_in(a), .b_in(b), .prod(yc13));

  function automatic logic [15:0] low_mask(input int cut);
    return (cut < 0) ? 16'h0000 : 16'((32'd1 << (cut + 1)) - 32'd1);
  endfunction

  function automatic logic [15:0] model(input logic [7:0] x, input logic [7:0] z,
                                         input int cut, input int tie, input int fill);
    int unsigned acc = 0;
    int unsigned n = 0;
    for (int i = 0; i < 8; i++)
      for (int j = 0; j < 8; j++)
        if (i + j > cut) acc += 32'(x[i] & z[j]) << (i + j);
    if (tie != 0) begin
      for (int j = 2; j <= 7; j++)
        if (j - 1 <= cut && cut <= j + 6) n++;
      if (cut >= 7 && cut <= 13) n++;
      if (cut >= 8 && cut <= 13) n++;
      acc += n << (cut + 1);
    end
    return acc[15:0] | (fill != 0 ? low_mask(cut) : 16'h0000);
  endfunction

  task automatic check(input string tag, input logic [15:0] got, input logic [15:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s a=%h b=%h got=%h exp=%h", tag, a, b, got, exp);
    end
  endtask

  initial begin
    repeat (2) @(posedge clk);
    @(negedge clk);
    // R7: zero operands while held in reset
    check("R7 v01 zero", y01, 16'h01FF);
    check("R7 v10 zero", y10, 16'h1000);
    check("R7 v11 zero", y11, 16'h11FF);
    rst = 1'b0;
    for (int v = 0; v < 65536; v++) begin
      @(posedge clk);
      a = v[15:8];
      b = v[7:0];
      @(negedge clk);
      check("R1 exact",      yex,  16'(a * b));
      check("R1 exact model", yex, model(a, b, -1, 1, 1));
      check("R2 R3 v01",     y01,  model(a, b, 8, 0, 1));
      check("R2 R3 v00",     y00,  model(a, b, 8, 0, 0));
      check("R4 v10",        y10,  model(a, b, 8, 1, 0));
      check("R4 v11",        y11,  model(a, b, 8, 1, 1));
      check("R4 cut2",       yc2,  model(a, b, 2, 1, 1));
      check("R4 cut13",      yc13, model(a, b, 13, 1, 0));
      check("R6 cut0",       yc0,  {16'(a * b) & 16'hFFFE});
      check("R5 pair0",      y01 & ~low_mask(8), y00 & ~low_mask(8));
      check("R5 pair1",      y11 & ~low_mask(8), y10 & ~low_mask(8));
      if (a == 8'h00 || b == 8'h00) begin
        check("R7 v01", y01, 16'h01FF);
        check("R7 v11", y11, 16'h11FF);
      end
    end
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (WATCHDOG_CYCLES) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule